// File: doc/BRIEF.md
# Oldest-First Issue Scheduler with Round-Robin Unit Choice

This block is the buffer between instruction dispatch and the execution pipelines of an out-of-order core. Each dispatched micro-op brings an identifier, the resource group it needs, and a tag with a ready bit for each source operand. An entry whose operands are all present is eligible at once. Otherwise it waits until a result broadcast carries a matching tag. Every slot is in one of four states: empty, waiting, ready or issued.

Each cycle, every resource group may issue one micro-op: the oldest eligible entry of that group. Within the group, the execution unit is chosen by a round-robin pointer among the units that report themselves free. An issued entry holds its slot until the write-back input names it. The slot is then released and a retire notification is raised for one cycle. The block also provides an occupancy count and a histogram of how many micro-ops issued per cycle.

Top module: `issue_sched`

## Requirements
- R1: After reset, the buffer is empty: `occupancy` = 0, `full` = 0, `iss_valid` = 0, `ret_valid` = 0, and all histogram bins are 0.
- R2: A micro-op dispatched with all sources ready is stored on the dispatch clock edge and issues on the next edge. It therefore never issues in the cycle it arrives.
- R3: An entry with a source not ready cannot issue until `bc_valid` is high with `bc_tag` equal to that source's tag. A broadcast with any other tag has no effect. A broadcast sampled on the same edge as the dispatch also counts.
- R4: Each group issues at most one micro-op per cycle. Among the eligible entries of a group, the one dispatched earliest is taken, whatever order they became eligible in.
- R5: Group g owns global units g*UNITS_PER_GRP+k in `unit_free`, with k as the local index. The granted local unit is the first free unit at or after the group's pointer, wrapping round. The pointer resets to 0 and, on an issue only, moves to the granted index plus one, modulo the group size. `iss_unit` reports the local index.
- R6: A group with no free unit issues nothing. Its eligible entries stay in the buffer.
- R7: `full` is 1 when all DEPTH slots are occupied. A dispatch while `full` is 1 is dropped: occupancy does not change and the micro-op never issues.
- R8: `wb_valid` with `wb_id` equal to an issued entry frees that slot, and after that edge `ret_valid` = 1 and `ret_id` = `wb_id`. A write-back naming no issued entry is ignored: no retire and no change in occupancy.
- R9: `occupancy` equals the number of non-empty slots.
- R10: On each clock edge outside reset, histogram bin n increments, where n is the number of micro-ops issued on that edge. Bin n is `issue_hist[n*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_id | input | ID_W | Micro-op identifier |
| disp_grp | input | GRP_W | Requested resource group |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source s at bits s*TAG_W |
| disp_src_rdy | input | NSRC | Source already available, one bit per source |
| full | output | 1 | All slots occupied |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast destination tag |
| unit_free | input | NUM_GRP*UNITS_PER_GRP | Unit can accept a micro-op this cycle |
| iss_valid | output | NUM_GRP | Issue per group |
| iss_id | output | NUM_GRP*ID_W | Issued identifier per group |
| iss_unit | output | NUM_GRP*UIDX_W | Granted local unit per group |
| wb_valid | input | 1 | Write-back completion |
| wb_id | input | ID_W | Identifier reaching write-back |
| ret_valid | output | 1 | Retire notification |
| ret_id | output | ID_W | Identifier ready to retire |
| occupancy | output | OCC_W | Occupied slot count |
| issue_hist | output | (NUM_GRP+1)*CNT_W | Issue-count histogram bins |

## Verification
Occupancy updates on the edge that samples a dispatch. An issue appears on the outputs one edge later: two edges after the dispatch, or two edges after the waking broadcast. A retire notification follows one edge after write-back. A histogram bin moves on the edge that issues. The bench drives every input just after a falling edge and reads every output at a later falling edge, after counting the rising edges in between. It checks the issue signals at each intermediate falling edge, so an early issue shows up as a failure as well as a late one.

// File: rtl/issue_sched_pkg.sv
package issue_sched_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY  = 2'd0,
    SLOT_WAIT   = 2'd1,
    SLOT_READY  = 2'd2,
    SLOT_ISSUED = 2'd3
  } slot_st_e;
endpackage

// File: rtl/sched_age_matrix.sv
module sched_age_matrix #(
  parameter int DEPTH   = 4,
  parameter int NUM_GRP = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [DEPTH-1:0]               alloc_oh,
  input  logic [NUM_GRP-1:0][DEPTH-1:0]  req,
  output logic [NUM_GRP-1:0][DEPTH-1:0]  gnt
);
  // older_q[a][b] = 1 means slot a holds an earlier dispatch than slot b
  logic [DEPTH-1:0] older_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int a = 0; a < DEPTH; a++) older_q[a] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_oh[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            if (j != k) begin
              older_q[k][j] <= 1'b0;
              older_q[j][k] <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int i = 0; i < DEPTH; i++) begin
        gnt[g][i] = req[g][i];
        for (int j = 0; j < DEPTH; j++) begin
          if (req[g][j] && older_q[j][i]) gnt[g][i] = 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    a_r4_one_grant: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt[g]));
    for (genvar i = 0; i < DEPTH; i++) begin : g_i
      for (genvar j = 0; j < DEPTH; j++) begin : g_j
        if (i != j) begin : g_pair
          a_r4_oldest_wins: assert property (@(posedge clk) disable iff (rst)
            (gnt[g][i] && req[g][j]) |-> older_q[i][j]);
        end
      end
    end
  end
endmodule

// File: rtl/sched_rr_pick.sv
module sched_rr_pick #(
  parameter int UPG    = 2,
  parameter int UIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [UPG-1:0]    free,
  input  logic              advance,
  output logic              have,
  output logic [UIDX_W-1:0] pick
);
  logic [UIDX_W-1:0] ptr_q;

  always_comb begin
    have = 1'b0;
    pick = '0;
    for (int k = UPG - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(ptr_q) + k) % UPG;
      if (free[idx]) begin
        have = 1'b1;
        pick = UIDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (advance) ptr_q <= (int'(pick) == UPG - 1) ? '0 : pick + 1'b1;
  end

  a_r5_grant_free: assert property (@(posedge clk) disable iff (rst)
    advance |-> free[pick]);
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(ptr_q));
endmodule

// File: rtl/sched_issue_hist.sv
module sched_issue_hist #(
  parameter int NUM_GRP = 2,
  parameter int CNT_W   = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GRP-1:0]             fire,
  output logic [(NUM_GRP+1)*CNT_W-1:0]   hist
);
  localparam int N_W = $clog2(NUM_GRP + 1);

  logic [CNT_W-1:0] bin_q [NUM_GRP+1];
  logic [N_W-1:0]   n_c;

  always_comb begin
    n_c = '0;
    for (int g = 0; g < NUM_GRP; g++) n_c = n_c + N_W'(fire[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= NUM_GRP; k++) bin_q[k] <= '0;
    end else begin
      bin_q[n_c] <= bin_q[n_c] + 1'b1;
    end
  end

  for (genvar k = 0; k <= NUM_GRP; k++) begin : g_out
    assign hist[k*CNT_W +: CNT_W] = bin_q[k];
  end
endmodule

// File: rtl/issue_sched.sv
module issue_sched
  import issue_sched_pkg::*;
#(
  parameter int DEPTH         = 4,
  parameter int NSRC          = 2,
  parameter int TAG_W         = 4,
  parameter int ID_W          = 4,
  parameter int NUM_GRP       = 2,
  parameter int UNITS_PER_GRP = 2,
  parameter int CNT_W         = 16,
  localparam int GRP_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int UIDX_W = (UNITS_PER_GRP > 1) ? $clog2(UNITS_PER_GRP) : 1,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               disp_valid,
  input  logic [ID_W-1:0]                    disp_id,
  input  logic [GRP_W-1:0]                   disp_grp,
  input  logic [NSRC*TAG_W-1:0]              disp_src_tag,
  input  logic [NSRC-1:0]                    disp_src_rdy,
  output logic                               full,
  input  logic                               bc_valid,
  input  logic [TAG_W-1:0]                   bc_tag,
  input  logic [NUM_GRP*UNITS_PER_GRP-1:0]   unit_free,
  output logic [NUM_GRP-1:0]                 iss_valid,
  output logic [NUM_GRP*ID_W-1:0]            iss_id,
  output logic [NUM_GRP*UIDX_W-1:0]          iss_unit,
  input  logic                               wb_valid,
  input  logic [ID_W-1:0]                    wb_id,
  output logic                               ret_valid,
  output logic [ID_W-1:0]                    ret_id,
  output logic [OCC_W-1:0]                   occupancy,
  output logic [(NUM_GRP+1)*CNT_W-1:0]       issue_hist
);
  // slot storage
  slot_st_e                      st_q  [DEPTH];
  logic [NSRC-1:0][TAG_W-1:0]    tag_q [DEPTH];
  logic [NSRC-1:0]               rdy_q [DEPTH];
  logic [GRP_W-1:0]              grp_q [DEPTH];
  logic [ID_W-1:0]               id_q  [DEPTH];

  logic [DEPTH-1:0]              occupied, alloc_oh, issue_mask, wb_hit;
  logic [NSRC-1:0]               wake [DEPTH];
  logic [NSRC-1:0]               disp_rdy_c;
  logic [NUM_GRP-1:0][DEPTH-1:0] req, oldest;
  logic [NUM_GRP-1:0]            have_unit, iss_fire;
  logic [NUM_GRP-1:0][UIDX_W-1:0] unit_pick;
  logic [NUM_GRP-1:0][ID_W-1:0]  iss_id_c;

  logic [NUM_GRP-1:0]            iss_valid_q;
  logic [NUM_GRP-1:0][ID_W-1:0]  iss_id_q;
  logic [NUM_GRP-1:0][UIDX_W-1:0] iss_unit_q;
  logic                          ret_valid_q;
  logic [ID_W-1:0]               ret_id_q;

  always_comb begin
    for (int s = 0; s < NSRC; s++)
      disp_rdy_c[s] = disp_src_rdy[s] |
                      (bc_valid && disp_src_tag[s*TAG_W +: TAG_W] == bc_tag);
  end

  // first empty slot takes the dispatch; none exists while full
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && !occupied[i]) begin
        alloc_oh[i] = disp_valid;
        found       = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign occupied[i] = (st_q[i] != SLOT_EMPTY);
    assign wb_hit[i]   = wb_valid && (st_q[i] == SLOT_ISSUED) && (id_q[i] == wb_id);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign wake[i][s] = bc_valid && (tag_q[i][s] == bc_tag);
    end
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_req
      assign req[g][i] = (st_q[i] == SLOT_READY) && (grp_q[i] == GRP_W'(g));
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[i]  <= SLOT_EMPTY;
        rdy_q[i] <= '0;
        tag_q[i] <= '0;
        grp_q[i] <= '0;
        id_q[i]  <= '0;
      end else if (alloc_oh[i]) begin
        tag_q[i] <= disp_src_tag;
        rdy_q[i] <= disp_rdy_c;
        grp_q[i] <= disp_grp;
        id_q[i]  <= disp_id;
        st_q[i]  <= (&disp_rdy_c) ? SLOT_READY : SLOT_WAIT;
      end else begin
        unique case (st_q[i])
          SLOT_WAIT: begin
            rdy_q[i] <= rdy_q[i] | wake[i];
            if (&(rdy_q[i] | wake[i])) st_q[i] <= SLOT_READY;
          end
          SLOT_READY:  if (issue_mask[i]) st_q[i] <= SLOT_ISSUED;
          SLOT_ISSUED: if (wb_hit[i])     st_q[i] <= SLOT_EMPTY;
          default: ;
        endcase
      end
    end

    a_r2_issue_after_ready: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] == SLOT_ISSUED && $past(st_q[i]) != SLOT_ISSUED)
        |-> $past(st_q[i]) == SLOT_READY);
    a_r3_wait_no_issue: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] == SLOT_WAIT) |=> st_q[i] != SLOT_ISSUED);
  end

  sched_age_matrix #(.DEPTH(DEPTH), .NUM_GRP(NUM_GRP)) u_age (
    .clk(clk), .rst(rst), .alloc_oh(alloc_oh), .req(req), .gnt(oldest)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    sched_rr_pick #(.UPG(UNITS_PER_GRP), .UIDX_W(UIDX_W)) u_rr (
      .clk(clk), .rst(rst),
      .free(unit_free[g*UNITS_PER_GRP +: UNITS_PER_GRP]),
      .advance(iss_fire[g]), .have(have_unit[g]), .pick(unit_pick[g])
    );
    assign iss_fire[g] = (|oldest[g]) && have_unit[g];
  end

  always_comb begin
    issue_mask = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      iss_id_c[g] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (oldest[g][i]) iss_id_c[g] = iss_id_c[g] | id_q[i];
      end
      if (iss_fire[g]) issue_mask = issue_mask | oldest[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid_q <= '0;
      iss_id_q    <= '0;
      iss_unit_q  <= '0;
      ret_valid_q <= 1'b0;
      ret_id_q    <= '0;
    end else begin
      iss_valid_q <= iss_fire;
      iss_id_q    <= iss_id_c;
      iss_unit_q  <= unit_pick;
      ret_valid_q <= |wb_hit;
      ret_id_q    <= wb_id;
    end
  end

  always_comb begin
    occupancy = '0;
    for (int i = 0; i < DEPTH; i++) occupancy = occupancy + OCC_W'(occupied[i]);
  end

  sched_issue_hist #(.NUM_GRP(NUM_GRP), .CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst(rst), .fire(iss_fire), .hist(issue_hist)
  );

  assign full      = &occupied;
  assign iss_valid = iss_valid_q;
  assign iss_id    = iss_id_q;
  assign iss_unit  = iss_unit_q;
  assign ret_valid = ret_valid_q;
  assign ret_id    = ret_id_q;

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (full && !(|wb_hit)) |=> occupancy == $past(occupancy));
  a_r8_retire_cause: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(wb_valid));
endmodule

// File: tb/tb_issue_sched.sv
module tb_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4, TAG_W = 4, CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        disp_valid = 1'b0;
  logic [3:0]  disp_id = '0;
  logic [0:0]  disp_grp = '0;
  logic [7:0]  disp_src_tag = '0;
  logic [1:0]  disp_src_rdy = '0;
  logic        full;
  logic        bc_valid = 1'b0;
  logic [3:0]  bc_tag = '0;
  logic [3:0]  unit_free = 4'b1111;
  logic [1:0]  iss_valid;
  logic [7:0]  iss_id;
  logic [1:0]  iss_unit;
  logic        wb_valid = 1'b0;
  logic [3:0]  wb_id = '0;
  logic        ret_valid;
  logic [3:0]  ret_id;
  logic [2:0]  occupancy;
  logic [47:0] issue_hist;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  issue_sched dut (
    .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_id(disp_id),
    .disp_grp(disp_grp), .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
    .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .unit_free(unit_free),
    .iss_valid(iss_valid), .iss_id(iss_id), .iss_unit(iss_unit),
    .wb_valid(wb_valid), .wb_id(wb_id), .ret_valid(ret_valid), .ret_id(ret_id),
    .occupancy(occupancy), .issue_hist(issue_hist)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int bin(input int n);
    return int'(issue_hist[n*CNT_W +: CNT_W]);
  endfunction

  // drive one dispatch for one cycle; returns at the falling edge after capture
  task automatic dispatch(input int id, input int grp, input int t0, input bit r0,
                          input int t1, input bit r1);
    disp_valid   = 1'b1;
    disp_id      = ID_W'(id);
    disp_grp     = 1'(grp);
    disp_src_tag = {TAG_W'(t1), TAG_W'(t0)};
    disp_src_rdy = {r1, r0};
    tick();
    disp_valid   = 1'b0;
  endtask

  task automatic writeback(input int id, input bit expect_ret);
    wb_valid = 1'b1;
    wb_id    = ID_W'(id);
    tick();
    wb_valid = 1'b0;
    check("R8", "ret_valid after write-back", ret_valid, expect_ret);
    if (expect_ret) check("R8", "ret_id", ret_id, id);
  endtask

  task automatic broadcast(input int tag);
    bc_valid = 1'b1;
    bc_tag   = TAG_W'(tag);
    tick();
    bc_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "occupancy", occupancy, 0);
    check("R1", "full", full, 0);
    check("R1", "iss_valid", iss_valid, 0);
    check("R1", "ret_valid", ret_valid, 0);
    check("R1", "hist bin0", bin(0), 0);
    check("R1", "hist bin2", bin(2), 0);
  endtask

  task automatic t_ready_issue();
    dispatch(1, 0, 0, 1, 0, 1);
    check("R9", "occupancy after dispatch", occupancy, 1);
    check("R2", "no issue in arrival cycle", iss_valid, 0);
    tick();
    check("R2", "issue valid grp0", iss_valid, 2'b01);
    check("R2", "issue id", iss_id[3:0], 1);
    check("R5", "first unit from pointer 0", iss_unit[0], 0);
    tick();
    check("R2", "issue is one cycle", iss_valid, 0);
    writeback(1, 1'b1);
    check("R8", "occupancy after retire", occupancy, 0);
    tick();
    check("R8", "ret_valid one cycle", ret_valid, 0);
  endtask

  task automatic t_round_robin();
    dispatch(2, 0, 0, 1, 0, 1);
    tick();
    check("R5", "pointer moved to unit 1", iss_unit[0], 1);
    writeback(2, 1'b1);
    unit_free = 4'b1110;
    dispatch(3, 0, 0, 1, 0, 1);
    tick();
    check("R5", "busy unit 0 skipped", iss_valid[0], 1);
    check("R5", "granted unit 1", iss_unit[0], 1);
    unit_free = 4'b1111;
    writeback(3, 1'b1);
    unit_free = 4'b1100;
    dispatch(4, 0, 0, 1, 0, 1);
    tick();
    check("R6", "no unit, no issue", iss_valid[0], 0);
    tick();
    check("R6", "still held", iss_valid[0], 0);
    check("R6", "entry kept", occupancy, 1);
    unit_free = 4'b1111;
    tick();
    check("R6", "issues once unit frees", iss_valid[0], 1);
    check("R6", "issued id", iss_id[3:0], 4);
    check("R5", "wrapped pointer gives unit 0", iss_unit[0], 0);
    writeback(4, 1'b1);
  endtask

  task automatic t_wakeup();
    dispatch(5, 1, 7, 0, 0, 1);
    tick();
    check("R3", "waiting entry not issued", iss_valid[1], 0);
    broadcast(3);
    tick();
    check("R3", "unrelated tag ignored", iss_valid[1], 0);
    broadcast(7);
    check("R3", "no issue on wake edge", iss_valid[1], 0);
    tick();
    check("R3", "issue after matching broadcast", iss_valid[1], 1);
    check("R3", "woken id", iss_id[7:4], 5);
    check("R5", "grp1 unit 0", iss_unit[1], 0);
    writeback(5, 1'b1);
    bc_valid = 1'b1;
    bc_tag   = 4'd9;
    dispatch(6, 1, 9, 0, 0, 1);
    bc_valid = 1'b0;
    check("R3", "bypass: no issue in arrival cycle", iss_valid[1], 0);
    tick();
    check("R3", "same-cycle broadcast counted", iss_valid[1], 1);
    check("R3", "bypass id", iss_id[7:4], 6);
    check("R5", "grp1 unit 1", iss_unit[1], 1);
    writeback(6, 1'b1);
  endtask

  task automatic t_oldest_first();
    unit_free = 4'b1100;
    dispatch(8, 0, 2, 0, 0, 1);
    dispatch(9, 0, 0, 1, 0, 1);
    dispatch(10, 0, 0, 1, 0, 1);
    broadcast(2);
    check("R4", "nothing issued while blocked", iss_valid, 0);
    unit_free = 4'b1111;
    tick();
    check("R4", "oldest first", iss_id[3:0], 8);
    check("R5", "unit for id 8", iss_unit[0], 1);
    tick();
    check("R4", "second oldest", iss_id[3:0], 9);
    check("R5", "unit for id 9", iss_unit[0], 0);
    tick();
    check("R4", "youngest last", iss_id[3:0], 10);
    check("R4", "one per cycle", iss_valid[0], 1);
    writeback(8, 1'b1);
    writeback(9, 1'b1);
    writeback(10, 1'b1);
  endtask

  task automatic t_full();
    for (int k = 11; k <= 14; k++) dispatch(k, 0, 15, 0, 0, 1);
    check("R7", "full flag", full, 1);
    check("R9", "occupancy at capacity", occupancy, 4);
    dispatch(15, 1, 0, 1, 0, 1);
    check("R7", "dropped dispatch, occupancy", occupancy, 4);
    tick();
    check("R7", "dropped micro-op not issued", iss_valid[1], 0);
    writeback(11, 1'b0);
    check("R8", "ignored write-back keeps slot", occupancy, 4);
    broadcast(15);
    for (int k = 11; k <= 14; k++) begin
      tick();
      check("R4", "drain order", iss_id[3:0], k);
      check("R7", "dropped micro-op never issues", iss_valid[1], 0);
    end
    for (int k = 11; k <= 14; k++) writeback(k, 1'b1);
    check("R7", "full cleared", full, 0);
    check("R9", "occupancy drained", occupancy, 0);
  endtask

  task automatic t_histogram();
    int s0, s1, s2;
    s0 = bin(0); s1 = bin(1); s2 = bin(2);
    repeat (5) tick();
    check("R10", "idle cycles in bin0", bin(0), s0 + 5);
    check("R10", "bin1 unchanged when idle", bin(1), s1);
    unit_free = 4'b0000;
    dispatch(1, 0, 0, 1, 0, 1);
    dispatch(2, 1, 0, 1, 0, 1);
    s0 = bin(0); s1 = bin(1); s2 = bin(2);
    unit_free = 4'b1111;
    tick();
    check("R4", "both groups issue together", iss_valid, 2'b11);
    check("R10", "bin2 counts dual issue", bin(2), s2 + 1);
    check("R10", "bin1 unchanged", bin(1), s1);
    check("R10", "bin0 unchanged", bin(0), s0);
    writeback(1, 1'b1);
    writeback(2, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ready_issue();
    t_round_robin();
    t_wakeup();
    t_oldest_first();
    t_full();
    t_histogram();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule